// File: doc/BRIEF.md
# Stepped-Level PWM Duty Generator

This block produces a fixed-frequency pulse-width waveform whose duty cycle is picked from a short ladder of coarse levels. A free-running prescale counter, clocked by the system clock, sets the period. The upper bits of that counter are compared against a threshold that a select code chooses. The lowest level is 5/16. Each higher code adds 1/16, up to 15/16. One further setting holds the output high for the whole period.

The stepped waveform is ANDed with an external pulse-width input. When both pulses start at the period boundary, the narrower pulse sets the combined duty. A new select code is sampled only as the counter wraps, so a period never contains a truncated pulse. A one-cycle strobe marks each period start so that the neighbouring logic can align to it.

Top module: `stepped_pwm_gen`

## Requirements
- R1: The period is 2**CNT_W clocks (256 by default). Every pulse is high from the first cycle of the period, which is the cycle in which the counter reads 0.
- R2: For a select code c from 0 to 10, `dig_pwm_o` is high while the counter's four upper bits are below 5+c. This gives (5+c)*16 high clocks in each 256-clock period.
- R3: Code 0 gives 80 high clocks per period (31.25%), and code 10 gives 240 (93.75%).
- R4: Code 11 holds `dig_pwm_o` high in every cycle of the period.
- R5: Codes 12 to 15 behave the same as code 11.
- R6: `comb_pwm_o` is high only when both `dig_pwm_o` and `ext_pwm_i` are high.
- R7: `period_start_o` is high for exactly one cycle, in the cycle in which the counter reads 0 after wrapping from 255. It is low in every other cycle, including the cycles that follow reset.
- R8: `sel_i` is sampled at the clock edge that wraps the counter from 255 to 0. A change at any other time has no effect on `dig_pwm_o` until that edge.
- R9: While `rst_ni` is low, the counter is 0 and the code behaves as code 0, so `dig_pwm_o` is high and `period_start_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 4 | Duty select code |
| ext_pwm_i | input | 1 | External pulse-width input |
| dig_pwm_o | output | 1 | Stepped-level waveform |
| comb_pwm_o | output | 1 | AND of the stepped waveform and the external input |
| period_start_o | output | 1 | One-cycle strobe at each counter wrap |

## Verification
Two events can fall in the same cycle: a change of the select code, and the wrap edge that loads the code. The bench changes `sel_i` in the last cycle before a wrap, and also in the middle of a period. It then checks, cycle by cycle, that the new level appears only from the first clock of the following period. The bench also varies `ext_pwm_i` so that the AND is exercised both with the external pulse wider than the stepped pulse and with it narrower.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  localparam int unsigned CNT_W   = 8;
  localparam int unsigned LVL_W   = 4;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned FLOOR   = 5;
  localparam int unsigned N_STEPS = (1 << LVL_W) - FLOOR;  // stepped levels below full
endpackage

// File: rtl/spwm_prescaler.sv
module spwm_prescaler #(
  parameter int unsigned CNT_W = spwm_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o,
  output logic             start_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             start_q;

  assign last_o  = (cnt_q == '1);
  assign cnt_o   = cnt_q;
  assign start_o = start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      start_q <= last_o;
    end
  end
endmodule

// File: rtl/spwm_sel_latch.sv
module spwm_sel_latch #(
  parameter int unsigned SEL_W = spwm_pkg::SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] sel_o
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (load_i) sel_q <= sel_i;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/spwm_level_cmp.sv
module spwm_level_cmp #(
  parameter int unsigned LVL_W   = spwm_pkg::LVL_W,
  parameter int unsigned SEL_W   = spwm_pkg::SEL_W,
  parameter int unsigned FLOOR   = spwm_pkg::FLOOR,
  parameter int unsigned N_STEPS = spwm_pkg::N_STEPS
) (
  input  logic [LVL_W-1:0] msb_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pwm_o
);
  localparam int unsigned TW = LVL_W + 1;

  logic [N_STEPS-1:0] line;

  // one comparator per stepped level
  for (genvar k = 0; k < N_STEPS; k++) begin : g_line
    assign line[k] = ({1'b0, msb_i} < TW'(FLOOR + k));
  end

  // codes past the last step give full duty
  always_comb begin
    pwm_o = 1'b1;
    for (int k = 0; k < N_STEPS; k++) begin
      if (sel_i == SEL_W'(k)) pwm_o = line[k];
    end
  end
endmodule

// File: rtl/stepped_pwm_gen.sv
module stepped_pwm_gen #(
  parameter int unsigned CNT_W = spwm_pkg::CNT_W,
  parameter int unsigned LVL_W = spwm_pkg::LVL_W,
  parameter int unsigned SEL_W = spwm_pkg::SEL_W,
  parameter int unsigned FLOOR = spwm_pkg::FLOOR
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ext_pwm_i,
  output logic             dig_pwm_o,
  output logic             comb_pwm_o,
  output logic             period_start_o
);
  localparam int unsigned N_STEPS = (1 << LVL_W) - FLOOR;

  logic [CNT_W-1:0] cnt;
  logic             last;
  logic [SEL_W-1:0] sel_q;

  spwm_prescaler #(.CNT_W(CNT_W)) i_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt),
    .last_o (last),
    .start_o(period_start_o)
  );

  spwm_sel_latch #(.SEL_W(SEL_W)) i_sel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(last),
    .sel_i (sel_i),
    .sel_o (sel_q)
  );

  spwm_level_cmp #(
    .LVL_W  (LVL_W),
    .SEL_W  (SEL_W),
    .FLOOR  (FLOOR),
    .N_STEPS(N_STEPS)
  ) i_cmp (
    .msb_i(cnt[CNT_W-1 -: LVL_W]),
    .sel_i(sel_q),
    .pwm_o(dig_pwm_o)
  );

  assign comb_pwm_o = dig_pwm_o & ext_pwm_i;
endmodule

// File: rtl/spwm_chk.sv
module spwm_chk #(
  parameter int unsigned CNT_W = spwm_pkg::CNT_W,
  parameter int unsigned LVL_W = spwm_pkg::LVL_W,
  parameter int unsigned SEL_W = spwm_pkg::SEL_W,
  parameter int unsigned FLOOR = spwm_pkg::FLOOR
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt,
  input logic [SEL_W-1:0] sel_q,
  input logic             ext_pwm_i,
  input logic             dig_pwm_o,
  input logic             comb_pwm_o,
  input logic             period_start_o
);
  localparam int unsigned N_STEPS = (1 << LVL_W) - FLOOR;

  a_r1_high_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_o |-> dig_pwm_o);

  a_r2_floor_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cnt[CNT_W-1 -: LVL_W]) < FLOOR) |-> dig_pwm_o);

  a_r4_full_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(sel_q) >= N_STEPS) |-> dig_pwm_o);

  a_r6_narrow_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comb_pwm_o |-> (dig_pwm_o && ext_pwm_i));

  a_r7_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_o |=> !period_start_o);

  a_r8_rise_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dig_pwm_o) |-> period_start_o);

  a_r8_sel_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_q) |-> (cnt == '0));
endmodule

bind stepped_pwm_gen spwm_chk #(
  .CNT_W(CNT_W), .LVL_W(LVL_W), .SEL_W(SEL_W), .FLOOR(FLOOR)
) i_spwm_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cnt           (cnt),
  .sel_q         (sel_q),
  .ext_pwm_i     (ext_pwm_i),
  .dig_pwm_o     (dig_pwm_o),
  .comb_pwm_o    (comb_pwm_o),
  .period_start_o(period_start_o)
);

// File: tb/test_stepped_pwm_gen.sv
module test_stepped_pwm_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] sel_i = 4'd0;
  logic       ext_pwm_i = 1'b1;
  logic       dig_pwm_o, comb_pwm_o, period_start_o;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // reference state
  int m_cnt = 0;
  int m_sel = 0;
  bit m_start = 1'b0;

  always #4 clk_i = ~clk_i;

  stepped_pwm_gen i_stepped_pwm_gen (
    .clk_i, .rst_ni, .sel_i, .ext_pwm_i,
    .dig_pwm_o, .comb_pwm_o, .period_start_o
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_sel = 0; m_start = 1'b0;
    end else begin
      m_start = (m_cnt == 255);
      if (m_cnt == 255) m_sel = int'(sel_i);
      m_cnt = (m_cnt + 1) % 256;
    end
  end

  function automatic bit exp_dig();
    if (m_sel >= 11) return 1'b1;
    return (m_cnt / 16) < (5 + m_sel);
  endfunction

  task automatic chk(input string req, input bit act, input bit exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cnt=%0d sel=%0d actual=%0b expected=%0b", req, m_cnt, m_sel, act, exp);
    end
  endtask

  task automatic check_all();
    string rq;
    if (!rst_ni) rq = "R9";
    else if (m_sel >= 12) rq = "R5";
    else if (m_sel == 11) rq = "R4";
    else rq = "R2/R8";
    chk(rq, dig_pwm_o, exp_dig());
    chk("R6", comb_pwm_o, exp_dig() & ext_pwm_i);
    chk(rst_ni ? "R7" : "R9", period_start_o, m_start);
  endtask

  // one cycle: check at falling edge, then drive
  task automatic cyc(input int sel, input bit ext);
    @(negedge clk_i);
    check_all();
    sel_i = 4'(sel);
    ext_pwm_i = ext;
  endtask

  // wait for a wrap, then count high clocks over one full period
  task automatic measure(input int code, input int exp_hi, input string req);
    int hi = 0;
    cyc(code, 1'b1);
    while (m_cnt != 0 || !m_start) cyc(code, 1'b1);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk_i);
      check_all();
      if (i == 0) chk("R1", dig_pwm_o, 1'b1);
      if (dig_pwm_o) hi++;
    end
    vectors++;
    if (hi != exp_hi) begin
      fails++;
      $display("FAIL %s code=%0d actual=%0d expected=%0d", req, code, hi, exp_hi);
    end
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk_i);
      check_all();  // R9 reset state
    end
    rst_ni = 1'b1;
    for (int i = 0; i < 300; i++) cyc(0, 1'b1);
    measure(0, 80, "R3");
    measure(10, 240, "R3");
    for (int c = 0; c < 16; c++) measure(c, (c >= 11) ? 256 : (5 + c) * 16, "R2");
    // R8: change code mid-period and on the last cycle before wrap
    for (int i = 0; i < 100; i++) cyc(3, 1'b1);
    for (int i = 0; i < 60; i++) cyc(9, 1'b1);
    while (m_cnt != 254) cyc(9, 1'b1);
    cyc(1, 1'b1);
    for (int i = 0; i < 300; i++) cyc(1, 1'b1);
    // R6: external pulse wider, then narrower
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 256; i++) cyc(2 + p * 3, (m_cnt < 40 + p * 70) ? 1'b1 : 1'b0);
    end
    for (int i = 0; i < 600; i++) cyc(i / 50, 1'($urandom_range(0, 1)));
    // R9: reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    sel_i = 4'd12;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      check_all();
    end
    rst_ni = 1'b1;
    for (int i = 0; i < 300; i++) cyc(12, 1'b1);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule